// File: doc/BRIEF.md
# UART Channel Interrupt Arbiter

This block gathers every interrupt cause of one serial channel: line errors, received data, receive idle timeout, transmit register empty, modem input changes, software flow control and the two hardware handshake lines. Each cause is held until the host acknowledges it in the way that cause requires. The block masks the held causes with an enable register. It reports only the most urgent cause that survives the mask, as a 4-bit code in an identification register. The causes themselves arrive as single-cycle event pulses, plus the receive FIFO fill count and its trigger level.

The host reaches the block through a small register port with a 3-bit address and read and write strobes. Reads of the receive data, line status and modem status addresses exist only to acknowledge causes, and they return zero. A single interrupt line goes to the host together with an output-enable. A strap input can force the enable on. Otherwise bit 3 of the modem control register sets it. The two handshake-line causes have the lowest urgency, so a more urgent cause hides them until that cause is serviced. Immediately after reset the transmit-empty cause is pending and enabled.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset the enable register reads 0x02, the modem control register reads 0x00, the transmit-empty cause is pending, the identification code is 0010 and irq_o is high.
- R2: Enable bits: bit 0 covers received data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status, bit 5 software flow, bit 6 RTS change and bit 7 CTS change. A cause whose bit is clear is neither reported nor drives irq_o, but it stays pending and appears once its bit is set.
- R3: Urgency from highest to lowest, with codes: line status 0110, timeout 1100, received data 0100, transmit empty 0010, modem status 0000, software flow 1000, CTS/RTS change 1010. The code 0001 means nothing is pending.
- R4: Received data is a level cause. It is active while rx_cnt_i >= rx_trig_i and inactive below that.
- R5: A timeout event is held only when rx_cnt_i is non-zero. Timeout and received data share one urgency level, and within that level timeout is shown. A held timeout clears on a read of address 0 or when rx_cnt_i is zero.
- R6: A transmit-empty event sets the transmit-empty cause. A write to address 0, or a read of address 2 while the code is 0010, clears it.
- R7: A read of address 2 clears the software flow cause while the code is 1000, and clears both handshake causes while the code is 1010. A read of address 5 clears line status. A read of address 6 clears modem status.
- R8: irq_o is high exactly when at least one enabled cause is pending.
- R9: irq_oe_o is high when strap_i is high. When strap_i is low, irq_oe_o equals modem control bit 3.
- R10: Address 1 is the enable register (read and write), address 2 reads {4'b0000, code}, and address 4 is the modem control register (read and write). Any other read returns 0.
- R11: When an event and a clear for the same cause fall in the same cycle, the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe, side effects on this cycle |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| ls_evt_i | input | 1 | Line status error event |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level |
| tmo_evt_i | input | 1 | Receive idle timeout event |
| thr_evt_i | input | 1 | Transmit register became empty |
| msr_evt_i | input | 1 | Modem input change event |
| swf_evt_i | input | 1 | Software flow character event |
| rts_evt_i | input | 1 | RTS change event |
| cts_evt_i | input | 1 | CTS change event |
| strap_i | input | 1 | Forces the interrupt output enable on |
| irq_o | output | 1 | Interrupt, active high |
| irq_oe_o | output | 1 | Output enable for irq_o |

## Verification
On every cycle the assertions check four things: irq_o agrees with the reported code, the strap forces the output enable on, a pending enabled line error always wins, and received data at or above trigger always shows one of the two receive codes. They also check that an acknowledging read drops transmit-empty on the next cycle and that an empty FIFO removes the timeout. Only the bench scenarios can show the full urgency ladder. They walk through a hidden handshake cause that appears after the modem cause is serviced, through causes that survive while masked and appear on enable, through the reset contents, and through the collision of set and clear in one cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 7;
  localparam int S_LS = 0;
  localparam int S_TMO = 1;
  localparam int S_THR = 2;
  localparam int S_MDM = 3;
  localparam int S_SWF = 4;
  localparam int S_RTS = 5;
  localparam int S_CTS = 6;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_IEN = 3'd1;
  localparam logic [2:0] A_ID = 3'd2;
  localparam logic [2:0] A_MCTL = 3'd4;
  localparam logic [2:0] A_LSTAT = 3'd5;
  localparam logic [2:0] A_MSTAT = 3'd6;

  typedef enum logic [3:0] {
    ID_NONE = 4'b0001,
    ID_LS   = 4'b0110,
    ID_RXD  = 4'b0100,
    ID_TMO  = 4'b1100,
    ID_THR  = 4'b0010,
    ID_MDM  = 4'b0000,
    ID_SWF  = 4'b1000,
    ID_FLOW = 4'b1010
  } irq_id_e;
endpackage

// File: rtl/uirq_pend.sv
module uirq_pend #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_d;

  always_comb begin
    pend_d = pend_o;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= RST_VAL;
    else         pend_o <= pend_d;
  end
endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  irq_id_e    code_i,
  output logic [7:0] rdata_o,
  output logic [7:0] ier_o,
  output logic [7:0] mcr_o,
  output logic       rd_data_o,
  output logic       wr_data_o,
  output logic       rd_id_o,
  output logic       rd_lstat_o,
  output logic       rd_mstat_o
);
  logic [7:0] ier_d, mcr_d;
  logic       ier_en, mcr_en;

  assign ier_en = wr_i && (addr_i == A_IEN);
  assign mcr_en = wr_i && (addr_i == A_MCTL);

  always_comb begin
    ier_d = ier_o;
    mcr_d = mcr_o;
    if (ier_en) ier_d = wdata_i;
    if (mcr_en) mcr_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_o <= 8'h02;
      mcr_o <= 8'h00;
    end else begin
      if (ier_en) ier_o <= ier_d;
      if (mcr_en) mcr_o <= mcr_d;
    end
  end

  assign rd_data_o  = rd_i && (addr_i == A_DATA);
  assign wr_data_o  = wr_i && (addr_i == A_DATA);
  assign rd_id_o    = rd_i && (addr_i == A_ID);
  assign rd_lstat_o = rd_i && (addr_i == A_LSTAT);
  assign rd_mstat_o = rd_i && (addr_i == A_MSTAT);

  always_comb begin
    unique case (addr_i)
      A_IEN:   rdata_o = ier_o;
      A_ID:    rdata_o = {4'b0000, code_i};
      A_MCTL:  rdata_o = mcr_o;
      default: rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0] pend_en_i,
  input  logic            rxrdy_en_i,
  output irq_id_e         code_o
);
  always_comb begin
    if (pend_en_i[S_LS])                         code_o = ID_LS;
    else if (pend_en_i[S_TMO])                   code_o = ID_TMO;
    else if (rxrdy_en_i)                         code_o = ID_RXD;
    else if (pend_en_i[S_THR])                   code_o = ID_THR;
    else if (pend_en_i[S_MDM])                   code_o = ID_MDM;
    else if (pend_en_i[S_SWF])                   code_o = ID_SWF;
    else if (pend_en_i[S_RTS] || pend_en_i[S_CTS]) code_o = ID_FLOW;
    else                                         code_o = ID_NONE;
  end
endmodule

// File: rtl/uirq_out.sv
module uirq_out
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0] pend_en_i,
  input  logic            rxrdy_en_i,
  input  logic            strap_i,
  input  logic            mcr_oe_i,
  output logic            irq_o,
  output logic            irq_oe_o
);
  assign irq_o    = (|pend_en_i) || rxrdy_en_i;
  assign irq_oe_o = strap_i || mcr_oe_i;
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uirq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             ls_evt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             tmo_evt_i,
  input  logic             thr_evt_i,
  input  logic             msr_evt_i,
  input  logic             swf_evt_i,
  input  logic             rts_evt_i,
  input  logic             cts_evt_i,
  input  logic             strap_i,
  output logic             irq_o,
  output logic             irq_oe_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  logic [7:0]      ier, mcr;
  logic            rd_data, wr_data, rd_id, rd_lstat, rd_mstat;
  irq_id_e         code;
  logic [NSRC-1:0] set_v, clr_v, pend, en_v, pend_en;
  logic            fifo_nz, rxrdy_en;

  uirq_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .addr_i     (addr_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .code_i     (code),
    .rdata_o    (rdata_o),
    .ier_o      (ier),
    .mcr_o      (mcr),
    .rd_data_o  (rd_data),
    .wr_data_o  (wr_data),
    .rd_id_o    (rd_id),
    .rd_lstat_o (rd_lstat),
    .rd_mstat_o (rd_mstat)
  );

  assign fifo_nz = (rx_cnt_i != CNT_ZERO);

  always_comb begin
    set_v        = '0;
    clr_v        = '0;
    set_v[S_LS]  = ls_evt_i;
    clr_v[S_LS]  = rd_lstat;
    set_v[S_TMO] = tmo_evt_i && fifo_nz;
    clr_v[S_TMO] = rd_data || !fifo_nz;
    set_v[S_THR] = thr_evt_i;
    clr_v[S_THR] = wr_data || (rd_id && code == ID_THR);
    set_v[S_MDM] = msr_evt_i;
    clr_v[S_MDM] = rd_mstat;
    set_v[S_SWF] = swf_evt_i;
    clr_v[S_SWF] = rd_id && code == ID_SWF;
    set_v[S_RTS] = rts_evt_i;
    clr_v[S_RTS] = rd_id && code == ID_FLOW;
    set_v[S_CTS] = cts_evt_i;
    clr_v[S_CTS] = rd_id && code == ID_FLOW;
  end

  always_comb begin
    en_v        = '0;
    en_v[S_LS]  = ier[2];
    en_v[S_TMO] = ier[0];
    en_v[S_THR] = ier[1];
    en_v[S_MDM] = ier[3];
    en_v[S_SWF] = ier[5];
    en_v[S_RTS] = ier[6];
    en_v[S_CTS] = ier[7];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    uirq_pend #(.RST_VAL(i == S_THR)) u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .pend_o (pend[i])
    );
  end

  assign pend_en  = pend & en_v;
  assign rxrdy_en = ier[0] && (rx_cnt_i >= rx_trig_i);

  uirq_prio u_prio (
    .pend_en_i  (pend_en),
    .rxrdy_en_i (rxrdy_en),
    .code_o     (code)
  );

  uirq_out u_out (
    .pend_en_i  (pend_en),
    .rxrdy_en_i (rxrdy_en),
    .strap_i    (strap_i),
    .mcr_oe_i   (mcr[3]),
    .irq_o      (irq_o),
    .irq_oe_o   (irq_oe_o)
  );
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ier,
  input logic [3:0]       code,
  input logic             ls_pend,
  input logic [2:0]       addr,
  input logic             rd,
  input logic             thr_evt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] rx_trig,
  input logic             strap,
  input logic             irq,
  input logic             irq_oe
);
  // R8: interrupt line agrees with the reported code
  a_r8_irq_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != 4'b0001));

  // R9: strap forces the output enable
  a_r9_strap_drives: assert property (@(posedge clk) disable iff (!rst_n)
    strap |-> irq_oe);

  // R3: an enabled line error always wins
  a_r3_ls_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && ls_pend) |-> code == 4'b0110);

  // R4: received data at trigger shows a receive code unless a line error wins
  a_r4_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[0] && rx_cnt >= rx_trig && !(ier[2] && ls_pend))
      |-> (code == 4'b0100 || code == 4'b1100));

  // R6: acknowledging read removes transmit-empty
  a_r6_thr_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 3'd2 && code == 4'b0010 && !thr_evt) |=> code != 4'b0010);

  // R5: empty FIFO removes the timeout
  a_r5_tmo_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) |=> code != 4'b1100);
endmodule

bind uart_irq_arbiter uirq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_n),
  .ier     (ier),
  .code    (code),
  .ls_pend (pend[0]),
  .addr    (addr_i),
  .rd      (rd_i),
  .thr_evt (thr_evt_i),
  .rx_cnt  (rx_cnt_i),
  .rx_trig (rx_trig_i),
  .strap   (strap_i),
  .irq     (irq_o),
  .irq_oe  (irq_oe_o)
);

// File: tb/uart_irq_arbiter_test.sv
`timescale 1ns/1ps
module uart_irq_arbiter_test;
  localparam int CNT_W = 7;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [2:0]       addr_i;
  logic             rd_i, wr_i;
  logic [7:0]       wdata_i, rdata_o;
  logic             ls_evt_i, tmo_evt_i, thr_evt_i, msr_evt_i;
  logic             swf_evt_i, rts_evt_i, cts_evt_i, strap_i;
  logic [CNT_W-1:0] rx_cnt_i, rx_trig_i;
  logic             irq_o, irq_oe_o;

  always #2.5 clk_i = ~clk_i;

  uart_irq_arbiter #(.CNT_W(CNT_W)) uut (.*);

  typedef struct {
    logic [7:0] data;
    logic       irq;
    logic       oe;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic exp_oe = 1'b0;

  // monitor: compares one expected item per falling edge
  initial forever begin
    @(negedge clk_i);
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (rdata_o !== e.data || irq_o !== e.irq || irq_oe_o !== e.oe) begin
        errors++;
        $display("FAIL %s: got data=%h irq=%b oe=%b expected data=%h irq=%b oe=%b",
                 e.tag, rdata_o, irq_o, irq_oe_o, e.data, e.irq, e.oe);
      end
    end
  end

  task automatic push_exp(input logic [2:0] a, input logic [7:0] d,
                          input logic irq, input string tag);
    exp_t e;
    addr_i = a;
    e.data = d; e.irq = irq; e.oe = exp_oe; e.tag = tag;
    sbq.push_back(e);
    wait (sbq.size() == 0);
    addr_i = 3'd2;
  endtask

  task automatic expect_id(input logic [3:0] c, input string tag);
    push_exp(3'd2, {4'b0000, c}, c != 4'b0001, tag);
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    step();
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    step();
    wr_i = 1'b0; addr_i = 3'd2;
  endtask

  task automatic bus_rd(input logic [2:0] a);
    step();
    addr_i = a; rd_i = 1'b1;
    step();
    rd_i = 1'b0; addr_i = 3'd2;
  endtask

  // order: {cts, rts, swf, msr, thr, tmo, ls}
  task automatic pulse(input logic [6:0] m);
    step();
    {cts_evt_i, rts_evt_i, swf_evt_i, msr_evt_i, thr_evt_i, tmo_evt_i, ls_evt_i} = m;
    step();
    {cts_evt_i, rts_evt_i, swf_evt_i, msr_evt_i, thr_evt_i, tmo_evt_i, ls_evt_i} = '0;
  endtask

  task automatic set_cnt(input int c);
    step();
    rx_cnt_i = CNT_W'(c);
    step();
  endtask

  initial begin
    #250000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; addr_i = 3'd2; rd_i = 0; wr_i = 0; wdata_i = 0;
    {cts_evt_i, rts_evt_i, swf_evt_i, msr_evt_i, thr_evt_i, tmo_evt_i, ls_evt_i} = '0;
    strap_i = 0; rx_cnt_i = 0; rx_trig_i = 4;
    repeat (3) step();
    rst_ni = 1'b1;
    repeat (4) step();

    // R1 reset state
    expect_id(4'b0010, "R1 reset code");
    push_exp(3'd1, 8'h02, 1'b1, "R1 reset enable reg");
    push_exp(3'd4, 8'h00, 1'b1, "R1 reset modem ctl");

    // R9 / R10 output enable control
    bus_wr(3'd4, 8'h08); exp_oe = 1'b1;
    push_exp(3'd4, 8'h08, 1'b1, "R10 R9 mctl bit3 drives");
    bus_wr(3'd4, 8'h00); strap_i = 1'b1; exp_oe = 1'b1;
    expect_id(4'b0010, "R9 strap forces enable");
    strap_i = 1'b0; exp_oe = 1'b0;
    expect_id(4'b0010, "R9 strap low bit3 clear");
    bus_wr(3'd4, 8'h08); exp_oe = 1'b1;

    // R6 ID read acknowledges transmit empty
    bus_rd(3'd2);
    expect_id(4'b0001, "R6 id read clears thr");

    bus_wr(3'd1, 8'hEF);
    push_exp(3'd1, 8'hEF, 1'b0, "R10 enable readback");

    // R3 / R7 handshake cause hidden by modem cause
    pulse(7'b1000000);
    expect_id(4'b1010, "R3 cts code");
    pulse(7'b0001000);
    expect_id(4'b0000, "R3 modem masks cts");
    bus_rd(3'd6);
    expect_id(4'b1010, "R7 msr read reveals cts");
    bus_rd(3'd2);
    expect_id(4'b0001, "R7 id read clears cts");

    // R4 / R5 receive level and timeout
    set_cnt(3);
    expect_id(4'b0001, "R4 below trigger");
    set_cnt(4);
    expect_id(4'b0100, "R4 at trigger");
    pulse(7'b0000010);
    expect_id(4'b1100, "R5 timeout over data");
    pulse(7'b0000001);
    expect_id(4'b0110, "R3 line status first");
    bus_rd(3'd5);
    expect_id(4'b1100, "R7 lsr read clears ls");
    bus_rd(3'd0);
    expect_id(4'b0100, "R5 data read clears timeout");
    set_cnt(3);
    expect_id(4'b0001, "R4 below trigger again");
    pulse(7'b0000010);
    expect_id(4'b1100, "R5 timeout under trigger");
    set_cnt(0);
    expect_id(4'b0001, "R5 empty fifo clears timeout");
    pulse(7'b0000010);
    expect_id(4'b0001, "R5 timeout ignored when empty");

    // R6 / R11 transmit empty
    pulse(7'b0000100);
    expect_id(4'b0010, "R6 thr event");
    bus_wr(3'd0, 8'h55);
    expect_id(4'b0001, "R6 thr write clears");
    step();
    addr_i = 3'd0; wr_i = 1'b1; thr_evt_i = 1'b1;
    step();
    wr_i = 1'b0; thr_evt_i = 1'b0; addr_i = 3'd2;
    expect_id(4'b0010, "R11 set wins over clear");
    bus_rd(3'd2);
    expect_id(4'b0001, "R6 id read clears thr again");

    // R3 / R7 software flow
    pulse(7'b0010000);
    expect_id(4'b1000, "R7 swf code");
    pulse(7'b0000100);
    expect_id(4'b0010, "R3 thr over swf");
    bus_rd(3'd2);
    expect_id(4'b1000, "R7 swf revealed");
    bus_rd(3'd2);
    expect_id(4'b0001, "R7 id read clears swf");

    // R2 masking keeps pending
    bus_wr(3'd1, 8'h00);
    pulse(7'b0001000);
    expect_id(4'b0001, "R2 masked modem hidden");
    bus_wr(3'd1, 8'h08);
    expect_id(4'b0000, "R2 modem appears on enable");
    bus_rd(3'd6);
    expect_id(4'b0001, "R7 msr read clears modem");
    bus_wr(3'd1, 8'h40);
    pulse(7'b0100000);
    expect_id(4'b1010, "R2 rts enabled by bit6");
    bus_rd(3'd2);
    pulse(7'b1000000);
    expect_id(4'b0001, "R2 cts masked by bit7");
    bus_wr(3'd1, 8'hC0);
    expect_id(4'b1010, "R2 cts appears on bit7");
    bus_rd(3'd2);
    expect_id(4'b0001, "R8 irq low when idle");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule